// File: doc/BRIEF.md
# Bit-Serial Pipelined Integer ALU

This block performs one of five integer operations on two 7-bit two's-complement operands that arrive one bit per clock, least significant bit first. Work is organised in fixed frames of eight clocks. A pulse on `frame_start_in` marks bit 0. The next six clocks carry bits 1 to 6. The eighth clock carries no data and is used only to put the carry/borrow state back to a known value, so frames can follow each other with no gap.

The opcode is captured on the frame-start clock and applies to the whole frame. The result leaves the block as a serial stream in the same bit order, after a fixed six-cycle pipeline. A copy of the frame-start pulse travels with the result so that a downstream stage can realign. Sums and differences wrap modulo 128, and no overflow indication is produced.

Top module: `serial_alu`

## Requirements
- R1: A clock with `frame_start_in` high carries operand bit 0. The following six clocks carry bits 1 to 6 in ascending order, and the seventh clock after the marker is the initialisation slot of the frame.
- R2: Opcode 3'b000 produces (A + B) mod 128, bit by bit, least significant bit first.
- R3: Opcode 3'b001 produces (A - B) mod 128. For example, A = 7'h40 (-64) and B = 7'h01 give 7'h3F.
- R4: Opcode 3'b010 produces A AND B, 3'b011 produces A OR B, and 3'b100 produces A XOR B, each bitwise.
- R5: The opcode is sampled only in the clock where `frame_start_in` is high. Values on `op_in` during the other clocks of the frame do not change the result.
- R6: Opcodes 3'b101, 3'b110 and 3'b111 produce an all-zero result stream.
- R7: A bit driven in input clock n appears on `res_bit` in clock n+6, and `frame_start_out` is `frame_start_in` delayed by exactly six clocks.
- R8: In the output clock that matches the initialisation slot, `res_bit` is 0 whatever the operand inputs were in that slot. The carry/borrow state is cleared in that slot, so a frame that follows at once is computed as if it stood alone.
- R9: Outside a frame (no marker and no frame in progress), `res_bit` is 0 and the operand and opcode inputs have no effect.
- R10: While `rst_n` is low, and for the first six clocks after it is released, `res_bit` and `frame_start_out` are 0.
- R11: A `frame_start_in` pulse that arrives before the initialisation slot abandons the current frame and starts a new frame at bit 0 with fresh carry state and a fresh opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start_in | input | 1 | High in the clock that carries operand bit 0 |
| op_in | input | 3 | Operation code, sampled with frame_start_in |
| a_bit | input | 1 | Serial operand A, LSB first |
| b_bit | input | 1 | Serial operand B, LSB first |
| res_bit | output | 1 | Serial result, LSB first |
| frame_start_out | output | 1 | Frame marker aligned with result bit 0 |

## Verification
The bench aims at carry chains that run across the full word, such as 63 + 1 and -64 - 1. A design that drops the borrow preset or inverts the wrong operand gives results that are off by one or negated. Frames follow each other with no gap, and random junk is driven on the operands in the initialisation slot and on the opcode in the middle of a frame. A carry that leaks between frames, or an opcode that is sampled again mid-frame, therefore corrupts the next result. A frame cut short by an early marker and undefined opcodes check that the framing restarts cleanly and that unused codes stay silent. Every output bit and marker is compared against a word-level model, so an off-by-one latency fails on the first frame.

// File: rtl/serial_alu_pkg.sv
package serial_alu_pkg;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_SUB = 3'd1,
    OP_AND = 3'd2,
    OP_OR  = 3'd3,
    OP_XOR = 3'd4
  } alu_op_e;

  // One bit slice: returns {carry_out, result_bit}.
  // For subtraction the B bit is inverted; the caller supplies carry_in = 1 on bit 0.
  function automatic logic [1:0] slice_eval(input logic [2:0] op,
                                            input logic a,
                                            input logic b,
                                            input logic cin);
    logic bb;
    logic [1:0] r;
    bb = (op == OP_SUB) ? ~b : b;
    case (op)
      OP_ADD, OP_SUB: r = {(a & bb) | (a & cin) | (bb & cin), a ^ bb ^ cin};
      OP_AND:         r = {1'b0, a & b};
      OP_OR:          r = {1'b0, a | b};
      OP_XOR:         r = {1'b0, a ^ b};
      default:        r = 2'b00;
    endcase
    return r;
  endfunction

  function automatic logic first_carry(input logic [2:0] op);
    return (op == OP_SUB);
  endfunction

endpackage

// File: rtl/sa_input_stage.sv
module sa_input_stage #(
  parameter int OP_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fs_i,
  input  logic [OP_W-1:0] op_i,
  input  logic            a_i,
  input  logic            b_i,
  output logic            fs_o,
  output logic [OP_W-1:0] op_o,
  output logic            a_o,
  output logic            b_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fs_o <= 1'b0;
      op_o <= '0;
      a_o  <= 1'b0;
      b_o  <= 1'b0;
    end else begin
      fs_o <= fs_i;
      op_o <= op_i;
      a_o  <= a_i;
      b_o  <= b_i;
    end
  end
endmodule

// File: rtl/sa_bit_engine.sv
module sa_bit_engine
  import serial_alu_pkg::*;
#(
  parameter int WORD_BITS = 7,
  parameter int FRAME_LEN = WORD_BITS + 1,
  parameter int OP_W      = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fs_i,
  input  logic [OP_W-1:0] op_i,
  input  logic            a_i,
  input  logic            b_i,
  output logic            fs_o,
  output logic            bit_o,
  output logic            init_slot_o,
  output logic            carry_o
);
  localparam int PW = $clog2(FRAME_LEN);
  localparam logic [PW-1:0] LAST_POS = PW'(FRAME_LEN - 1);
  localparam logic [PW-1:0] INIT_POS = PW'(WORD_BITS);

  logic [PW-1:0]   pos_q;
  logic            active_q;
  logic [OP_W-1:0] op_q;
  logic            carry_q;

  logic [OP_W-1:0] cur_op;
  logic            data_slot;
  logic            init_slot;
  logic            cin;
  logic [1:0]      slice;

  always_comb begin
    cur_op    = fs_i ? op_i : op_q;
    data_slot = fs_i || (active_q && (pos_q < INIT_POS));
    init_slot = !fs_i && active_q && (pos_q == INIT_POS);
    cin       = fs_i ? first_carry(op_i) : carry_q;
    slice     = slice_eval(cur_op, a_i, b_i, cin);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_q    <= '0;
      active_q <= 1'b0;
      op_q     <= '0;
    end else if (fs_i) begin
      pos_q    <= PW'(1);
      active_q <= 1'b1;
      op_q     <= op_i;
    end else if (active_q) begin
      if (pos_q == LAST_POS) begin
        pos_q    <= '0;
        active_q <= 1'b0;
      end else begin
        pos_q <= pos_q + PW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         carry_q <= 1'b0;
    else if (init_slot) carry_q <= 1'b0;
    else if (data_slot) carry_q <= slice[1];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fs_o  <= 1'b0;
      bit_o <= 1'b0;
    end else begin
      fs_o  <= fs_i;
      bit_o <= data_slot ? slice[0] : 1'b0;
    end
  end

  assign init_slot_o = init_slot;
  assign carry_o     = carry_q;
endmodule

// File: rtl/sa_delay_line.sv
module sa_delay_line #(
  parameter int DEPTH = 4,
  parameter int WIDTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] d_o
);
  generate
    if (DEPTH == 0) begin : g_pass
      assign d_o = d_i;
    end else begin : g_chain
      logic [WIDTH-1:0] stage_q [DEPTH];
      for (genvar i = 0; i < DEPTH; i++) begin : g_stage
        always_ff @(posedge clk) begin
          if (!rst_n) stage_q[i] <= '0;
          else        stage_q[i] <= (i == 0) ? d_i : stage_q[(i == 0) ? 0 : i-1];
        end
      end
      assign d_o = stage_q[DEPTH-1];
    end
  endgenerate
endmodule

// File: rtl/serial_alu.sv
module serial_alu #(
  parameter int WORD_BITS   = 7,
  parameter int PIPE_STAGES = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frame_start_in,
  input  logic [2:0] op_in,
  input  logic       a_bit,
  input  logic       b_bit,
  output logic       res_bit,
  output logic       frame_start_out
);
  localparam int FRAME_LEN = WORD_BITS + 1;
  localparam int TAIL      = PIPE_STAGES - 2;
  localparam int OP_W      = 3;

  logic            s1_fs, s1_a, s1_b;
  logic [OP_W-1:0] s1_op;
  logic            s2_fs, s2_bit;
  logic            w_init, w_carry;
  logic [1:0]      tail_out;

  sa_input_stage #(.OP_W(OP_W)) u_in (
    .clk(clk), .rst_n(rst_n),
    .fs_i(frame_start_in), .op_i(op_in), .a_i(a_bit), .b_i(b_bit),
    .fs_o(s1_fs), .op_o(s1_op), .a_o(s1_a), .b_o(s1_b)
  );

  sa_bit_engine #(.WORD_BITS(WORD_BITS), .FRAME_LEN(FRAME_LEN), .OP_W(OP_W)) u_eng (
    .clk(clk), .rst_n(rst_n),
    .fs_i(s1_fs), .op_i(s1_op), .a_i(s1_a), .b_i(s1_b),
    .fs_o(s2_fs), .bit_o(s2_bit),
    .init_slot_o(w_init), .carry_o(w_carry)
  );

  sa_delay_line #(.DEPTH(TAIL), .WIDTH(2)) u_tail (
    .clk(clk), .rst_n(rst_n),
    .d_i({s2_fs, s2_bit}),
    .d_o(tail_out)
  );

  assign frame_start_out = tail_out[1];
  assign res_bit         = tail_out[0];
endmodule

// File: rtl/serial_alu_checker.sv
module serial_alu_checker #(
  parameter int WORD_BITS   = 7,
  parameter int PIPE_STAGES = 6
) (
  input logic clk,
  input logic rst_n,
  input logic frame_start_in,
  input logic frame_start_out,
  input logic res_bit,
  input logic eng_init,
  input logic eng_carry
);
  localparam int FRAME_LEN = WORD_BITS + 1;
  localparam int CW = $clog2(FRAME_LEN + 1);
  localparam int RW = $clog2(PIPE_STAGES + 1);

  logic [PIPE_STAGES-1:0] fs_hist;
  logic [CW-1:0]          out_pos;
  logic [RW-1:0]          since_rst;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fs_hist   <= '0;
      out_pos   <= '0;
      since_rst <= '0;
    end else begin
      fs_hist <= {fs_hist[PIPE_STAGES-2:0], frame_start_in};
      if (frame_start_out)                                 out_pos <= CW'(1);
      else if (out_pos != '0 && out_pos < CW'(FRAME_LEN))  out_pos <= out_pos + CW'(1);
      else                                                 out_pos <= '0;
      if (since_rst < RW'(PIPE_STAGES)) since_rst <= since_rst + RW'(1);
    end
  end

  AST_MARKER_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start_out == fs_hist[PIPE_STAGES-1]); // R7

  AST_CARRY_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    eng_init |=> !eng_carry); // R8

  AST_INIT_SLOT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (out_pos == CW'(WORD_BITS) && !frame_start_out) |-> !res_bit); // R8

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst < RW'(PIPE_STAGES)) |-> (!res_bit && !frame_start_out)); // R10
endmodule

bind serial_alu serial_alu_checker #(.WORD_BITS(WORD_BITS), .PIPE_STAGES(PIPE_STAGES)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .frame_start_in(frame_start_in), .frame_start_out(frame_start_out),
  .res_bit(res_bit), .eng_init(w_init), .eng_carry(w_carry)
);

// File: tb/serial_alu_bench.sv
module serial_alu_bench;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n, fs, a, b;
  logic [2:0] op;
  wire        res, fso;

  serial_alu u_serial_alu (
    .clk(clk), .rst_n(rst_n), .frame_start_in(fs), .op_in(op),
    .a_bit(a), .b_bit(b), .res_bit(res), .frame_start_out(fso)
  );

  int    n_run = 0, n_fail = 0;
  bit    exp_b [6];
  bit    exp_f [6];
  string tag_h [6];

  function automatic int model(input int aw, input int bw, input int o);
    case (o)
      0: return (aw + bw) & 127;
      1: return (aw - bw) & 127;
      2: return aw & bw;
      3: return aw | bw;
      4: return aw ^ bw;
      default: return 0;  // R6
    endcase
  endfunction

  function automatic string tag_of(input int o);
    case (o)
      0: return "R2";
      1: return "R3";
      2, 3, 4: return "R4";
      default: return "R6";
    endcase
  endfunction

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  // One clock: check the output that belongs to the input six clocks back (R7),
  // then drive this clock's inputs and record what they must produce.
  task automatic step(input bit f, input bit [2:0] o, input bit ai, input bit bi,
                      input bit eb, input string tg);
    @(negedge clk);
    n_run++;
    if (res !== exp_b[5]) begin
      n_fail++;
      $display("FAIL %s res_bit got %b expected %b", tag_h[5], res, exp_b[5]);
    end
    n_run++;
    if (fso !== exp_f[5]) begin
      n_fail++;
      $display("FAIL R7 frame_start_out got %b expected %b", fso, exp_f[5]);
    end
    for (int k = 5; k > 0; k--) begin
      exp_b[k] = exp_b[k-1];
      exp_f[k] = exp_f[k-1];
      tag_h[k] = tag_h[k-1];
    end
    exp_b[0] = eb; exp_f[0] = f; tag_h[0] = tg;
    fs = f; op = o; a = ai; b = bi;
  endtask

  // R1: bit 0 on the marker clock, bits 1..6 after it, slot 7 is initialisation.
  task automatic frame(input int aw, input int bw, input int o, input int len,
                       input bit junk_op, input string force_tag);
    int    r;
    string tg;
    r  = model(aw, bw, o);
    tg = (force_tag != "") ? force_tag : tag_of(o);
    for (int i = 0; i < len; i++) begin
      bit [2:0] od;
      bit ai, bi, eb;
      od = (i == 0 || !junk_op) ? 3'(o) : 3'($urandom);  // R5
      if (i < 7) begin
        ai = bit'((aw >> i) & 1); bi = bit'((bw >> i) & 1);
        eb = bit'((r >> i) & 1);
        step(i == 0, od, ai, bi, eb, tg);
      end else begin
        step(1'b0, od, 1'($urandom), 1'($urandom), 1'b0, "R8");
      end
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++)
      step(1'b0, 3'($urandom), 1'($urandom), 1'($urandom), 1'b0, "R9");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R7 watchdog: run got no end expected completion");
    summary();
    $finish;
  end

  initial begin
    for (int k = 0; k < 6; k++) begin exp_b[k] = 0; exp_f[k] = 0; tag_h[k] = "R10"; end
    rst_n = 1'b0; fs = 1'b0; op = 3'd0; a = 1'b1; b = 1'b1;
    repeat (3) @(negedge clk);
    n_run++;
    if (res !== 1'b0 || fso !== 1'b0) begin
      n_fail++;
      $display("FAIL R10 reset outputs got %b%b expected 00", res, fso);
    end
    rst_n = 1'b1;

    frame(5, 3, 0, 8, 0, "R1");
    frame(7'h3F, 7'h01, 0, 8, 0, "");   // 63 + 1 wraps to -64, R2
    frame(7'h40, 7'h01, 1, 8, 0, "");   // -64 - 1 wraps to 63, R3
    frame(7'h00, 7'h7F, 1, 8, 0, "");   // 0 - (-1) = 1, R3
    frame(7'h55, 7'h33, 2, 8, 0, "");   // R4 AND
    frame(7'h55, 7'h33, 3, 8, 0, "");   // R4 OR
    frame(7'h55, 7'h33, 4, 8, 0, "");   // R4 XOR
    frame(7'h7F, 7'h7F, 5, 8, 0, "");   // R6
    frame(7'h7F, 7'h01, 7, 8, 0, "");   // R6
    frame(7'h2B, 7'h19, 1, 8, 1, "R5");
    idle(5);                            // R9
    frame(7'h7F, 7'h7F, 0, 4, 0, "R11");
    frame(7'h12, 7'h34, 1, 8, 0, "R11");
    for (int n = 0; n < 200; n++) begin
      int o;
      o = ($urandom % 8 == 0) ? 5 + int'($urandom % 3) : int'($urandom % 5);
      frame(int'($urandom % 128), int'($urandom % 128), o, 8, ($urandom % 4 == 0), "");
      if ($urandom % 6 == 0) idle(1 + int'($urandom % 3));
    end
    idle(8);
    summary();
    $finish;
  end
endmodule